// File: doc/BRIEF.md
# Serial Bus Frame-Boundary Timer

This block watches a single-wire, variable-pulse-width serial bus while it sits in its passive level. It counts timebase ticks for as long as the line stays low and sorts the gap into three classes. A gap that reaches the short threshold closes the data part of a message. A gap that reaches the longer threshold closes the whole frame. A gap that reaches the longest threshold completes the separation between frames, and only after that point may a node start a new frame.

The block also decides when a transmit request may begin. A write strobe from the transmit path queues a request, and the request stays queued until it is granted. A request is normally granted once the separation time has passed. Another node may start a frame while the separation window is still open, which can happen when node clocks differ slightly. In that case the block treats the rising edge as a start-of-frame and resynchronizes to it. The queued request is granted at that edge only if it was written at least a set number of ticks before the edge. A later request waits for the next complete separation period. A break seen while this node is transmitting is handled as a transmit error and aborts the transmission.

Bit encoding, arbitration, CRC and byte storage belong to other blocks. This block only times passive periods and gates the start of transmission.

Top module: `frame_gap_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is low and the passive-time count is zero.
- R2: The passive-time count advances by one on each cycle where `tick_1us` is high and `rx_line` is low. It returns to zero on any cycle where `rx_line` is high. It stops at `T_IFS_TICKS` for as long as the line stays low.
- R3: `eod_pulse` is high for exactly one cycle, in the cycle after the tick that brings the passive count to `T_EOD_TICKS`. It fires at most once per passive gap and never fires for a gap shorter than `T_EOD_TICKS`.
- R4: `eof_pulse` is high for exactly one cycle, in the cycle after the tick that brings the passive count to `T_EOF_TICKS`. It fires at most once per passive gap.
- R5: `ifs_done` is high exactly while the passive count equals `T_IFS_TICKS`. It stays high while the line stays low, and it is low again one cycle after `rx_line` goes high.
- R6: A pulse on `data_wr` latches a transmit request. The request stays latched until it is granted. It is granted with a one-cycle `tx_grant` once `ifs_done` is high and the line is passive.
- R7: The separation window is the span where the passive count is at least `T_EOF_TICKS` and below `T_IFS_TICKS`. A rising edge of `rx_line` inside this window, with a request written at least `WRITE_LEAD_TICKS` ticks earlier, produces `tx_grant` in the cycle after the edge.
- R8: A request younger than `WRITE_LEAD_TICKS` ticks at such an edge gets no grant at the edge. It is granted only after the next full separation period.
- R9: A rising edge before the separation window opens grants nothing, even when the request is old enough.
- R10: `break_seen` while `tx_active` is high produces a one-cycle `tx_abort` in the next cycle. `break_seen` while `tx_active` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Synchronized receive line, high = active |
| tick_1us | input | 1 | One-cycle timebase tick |
| tx_active | input | 1 | This node is currently transmitting |
| break_seen | input | 1 | Break detected on the bus (strobe) |
| data_wr | input | 1 | Transmit data written (strobe), queues a request |
| eod_pulse | output | 1 | End of data reached in this gap |
| eof_pulse | output | 1 | End of frame reached in this gap |
| ifs_done | output | 1 | Separation time complete, bus free |
| tx_grant | output | 1 | One-cycle permission to start a frame |
| tx_abort | output | 1 | One-cycle transmit abort after a break |

## Verification
The bench builds the block with thresholds of 20, 28 and 34 ticks and a write lead of 10 ticks. It raises the tick on every fourth clock. With these values every gap class, saturation and the six-tick separation window can be reached in a few hundred cycles. Both sides of the lead rule can be placed in one window: an early write that is granted at the edge, and a write one tick before the edge that is held over. The gaps are chosen to show each case: one shorter than the end-of-data threshold, one that ends between end-of-data and end-of-frame, and one that runs to completion.

// File: rtl/fgt_pkg.sv
package fgt_pkg;

  // True when a passive count lies in the resync window [t_eof, t_ifs)
  function automatic logic in_sep_window(input logic [31:0] gap,
                                         input logic [31:0] t_eof,
                                         input logic [31:0] t_ifs);
    return (gap >= t_eof) && (gap < t_ifs);
  endfunction

  // True when the tick moving the count off 'gap' lands on 'thr'
  function automatic logic crossing(input logic [31:0] gap,
                                    input logic [31:0] thr);
    return (gap + 32'd1) == thr;
  endfunction

  // True when a queued write is old enough to join a resync edge
  function automatic logic write_ripe(input logic [31:0] age,
                                      input logic [31:0] lead);
    return age >= lead;
  endfunction

endpackage

// File: rtl/gap_meter.sv
module gap_meter #(
  parameter int T_EOD = 200,
  parameter int T_EOF = 280,
  parameter int T_IFS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic tick,
  output logic eod_pulse,
  output logic eof_pulse,
  output logic ifs_done,
  output logic sep_window,
  output logic rx_rise
);
  import fgt_pkg::*;

  localparam int CW = $clog2(T_IFS + 1);

  logic [CW-1:0] gap_cnt;
  logic          rx_q;
  logic          step;

  assign rx_rise    = rx & ~rx_q;
  assign step       = tick && !rx && (gap_cnt != CW'(T_IFS));
  assign ifs_done   = (gap_cnt == CW'(T_IFS));
  assign sep_window = in_sep_window(32'(gap_cnt), T_EOF, T_IFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      rx_q      <= 1'b0;
      eod_pulse <= 1'b0;
      eof_pulse <= 1'b0;
    end else begin
      rx_q      <= rx;
      eod_pulse <= step && crossing(32'(gap_cnt), T_EOD);
      eof_pulse <= step && crossing(32'(gap_cnt), T_EOF);
      if (rx)
        gap_cnt <= '0;
      else if (step)
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R2
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= CW'(T_IFS));

  // R2
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx |=> (gap_cnt == '0));

  // R3
  eod_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_pulse |=> !eod_pulse);

  // R4
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |=> !eof_pulse);

  // R5
  ifs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifs_done && !rx) |=> ifs_done);

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
  parameter int LEAD = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr_strobe,
  input  logic rx,
  input  logic rx_rise,
  input  logic ifs_done,
  input  logic sep_window,
  output logic tx_grant
);
  import fgt_pkg::*;

  localparam int AW = $clog2(LEAD + 1);

  logic          pending_q;
  logic [AW-1:0] age_q;
  logic          ripe;
  logic          grant_idle;
  logic          grant_sync;
  logic          grant_now;

  assign ripe       = write_ripe(32'(age_q), LEAD);
  assign grant_idle = pending_q && ifs_done && !rx;
  assign grant_sync = pending_q && rx_rise && sep_window && ripe;
  assign grant_now  = grant_idle || grant_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      age_q     <= '0;
      tx_grant  <= 1'b0;
    end else begin
      tx_grant  <= grant_now;
      pending_q <= wr_strobe || (pending_q && !grant_now);
      if (wr_strobe && (!pending_q || grant_now))
        age_q <= '0;
      else if (pending_q && tick && (age_q != AW'(LEAD)))
        age_q <= age_q + 1'b1;
    end
  end

  // R6
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> $past(pending_q));

  // R8
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && rx_rise && !ripe) |=> !tx_grant);

  // R9
  off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rise && !sep_window) |=> !tx_grant);

endmodule

// File: rtl/break_abort.sv
module break_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic break_seen,
  output logic tx_abort
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      tx_abort <= 1'b0;
    else
      tx_abort <= tx_active && break_seen;
  end

  // R10
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(tx_active));

endmodule

// File: rtl/frame_gap_timer.sv
module frame_gap_timer #(
  parameter int T_EOD_TICKS      = 200,
  parameter int T_EOF_TICKS      = 280,
  parameter int T_IFS_TICKS      = 300,
  parameter int WRITE_LEAD_TICKS = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic tick_1us,
  input  logic tx_active,
  input  logic break_seen,
  input  logic data_wr,
  output logic eod_pulse,
  output logic eof_pulse,
  output logic ifs_done,
  output logic tx_grant,
  output logic tx_abort
);

  logic sep_window;
  logic rx_rise;

  gap_meter #(
    .T_EOD(T_EOD_TICKS),
    .T_EOF(T_EOF_TICKS),
    .T_IFS(T_IFS_TICKS)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx        (rx_line),
    .tick      (tick_1us),
    .eod_pulse (eod_pulse),
    .eof_pulse (eof_pulse),
    .ifs_done  (ifs_done),
    .sep_window(sep_window),
    .rx_rise   (rx_rise)
  );

  tx_start_gate #(
    .LEAD(WRITE_LEAD_TICKS)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1us),
    .wr_strobe (data_wr),
    .rx        (rx_line),
    .rx_rise   (rx_rise),
    .ifs_done  (ifs_done),
    .sep_window(sep_window),
    .tx_grant  (tx_grant)
  );

  break_abort u_abort (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .break_seen(break_seen),
    .tx_abort  (tx_abort)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !(eod_pulse || eof_pulse || ifs_done || tx_grant || tx_abort));

endmodule

// File: tb/frame_gap_timer_tb.sv
module frame_gap_timer_tb;

  localparam int T_EOD = 20;
  localparam int T_EOF = 28;
  localparam int T_IFS = 34;
  localparam int LEAD  = 10;

  localparam int EV_EOD   = 1;
  localparam int EV_EOF   = 2;
  localparam int EV_GRANT = 3;
  localparam int EV_ABORT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b0;
  logic tick_1us = 1'b0;
  logic tx_active = 1'b0;
  logic break_seen = 1'b0;
  logic data_wr = 1'b0;
  logic eod_pulse, eof_pulse, ifs_done, tx_grant, tx_abort;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int m_gap = 0;
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;

  frame_gap_timer #(
    .T_EOD_TICKS(T_EOD),
    .T_EOF_TICKS(T_EOF),
    .T_IFS_TICKS(T_IFS),
    .WRITE_LEAD_TICKS(LEAD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick_1us(tick_1us),
    .tx_active(tx_active), .break_seen(break_seen), .data_wr(data_wr),
    .eod_pulse(eod_pulse), .eof_pulse(eof_pulse), .ifs_done(ifs_done),
    .tx_grant(tx_grant), .tx_abort(tx_abort)
  );

  // timebase: one tick every fourth clock
  always @(posedge clk) begin
    #1;
    tdiv = tdiv + 2'd1;
    tick_1us = (tdiv == 2'd0);
  end

  function automatic string ev_req(input int k);
    case (k)
      EV_EOD:   return "R3";
      EV_EOF:   return "R4";
      EV_GRANT: return "R6/R7/R8";
      default:  return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int k);
    exp_q.push_back(k);
  endtask

  // monitor: compares observed pulses with the queue, then models the gap
  task automatic got(input int k);
    int e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual event %0d expected none", ev_req(k), k);
    end else begin
      e = exp_q.pop_front();
      if (e != k) begin
        errors++;
        $display("FAIL %s: actual event %0d expected event %0d", ev_req(e), k, e);
      end else if (k == EV_EOD && m_gap != T_EOD) begin
        errors++;
        $display("FAIL R3: actual gap %0d expected %0d", m_gap, T_EOD);
      end else if (k == EV_EOF && m_gap != T_EOF) begin
        errors++;
        $display("FAIL R4: actual gap %0d expected %0d", m_gap, T_EOF);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (eod_pulse) got(EV_EOD);
      if (eof_pulse) got(EV_EOF);
      if (tx_grant)  got(EV_GRANT);
      if (tx_abort)  got(EV_ABORT);
    end
    if (!rst_n || rx_line) m_gap = 0;
    else if (tick_1us && m_gap < T_IFS) m_gap++;
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick_1us);
    end
    #2;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_wr;
    data_wr = 1'b1;
    clocks(1);
    data_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    clocks(3);
    // R1: outputs quiet in reset
    chk("R1", int'({eod_pulse, eof_pulse, ifs_done, tx_grant, tx_abort}), 0);
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    rst_n = 1'b1;
    clocks(1);
    chk("R1", int'({eod_pulse, eof_pulse, ifs_done, tx_grant, tx_abort}), 0);

    // R5/R2: idle line reaches separation and saturates there
    wait_ticks(T_IFS + 3);
    chk("R5", int'(ifs_done), 1);
    wait_ticks(5);
    chk("R2", int'(ifs_done), 1);

    // R6: write on an idle bus is granted
    expect_ev(EV_GRANT);
    pulse_wr();
    clocks(4);

    // R5: a frame clears the separation indication
    rx_line = 1'b1;
    clocks(2);
    chk("R5", int'(ifs_done), 0);
    wait_ticks(5);
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    rx_line = 1'b0;
    wait_ticks(T_IFS + 2);
    chk("R5", int'(ifs_done), 1);

    // R3: short gap gives no pulse
    rx_line = 1'b1;
    wait_ticks(2);
    rx_line = 1'b0;
    wait_ticks(10);
    chk("R3", int'(ifs_done), 0);
    rx_line = 1'b1;
    wait_ticks(2);

    // R7: early write, edge inside the window is granted at the edge
    pulse_wr();
    wait_ticks(3);
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    expect_ev(EV_GRANT);
    rx_line = 1'b0;
    wait_ticks(T_EOF + 2);
    rx_line = 1'b1;
    clocks(2);
    chk("R7", exp_q.size(), 0);
    wait_ticks(3);

    // R8: late write in the window is held to the next separation
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    rx_line = 1'b0;
    wait_ticks(T_EOF + 1);
    pulse_wr();
    wait_ticks(1);
    rx_line = 1'b1;
    clocks(2);
    chk("R8", int'(tx_grant), 0);
    wait_ticks(3);
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    expect_ev(EV_GRANT);
    rx_line = 1'b0;
    wait_ticks(T_IFS + 3);
    chk("R8", exp_q.size(), 0);

    // R9: ripe write, edge before the window opens grants nothing
    rx_line = 1'b1;
    pulse_wr();
    wait_ticks(LEAD + 2);
    expect_ev(EV_EOD);
    rx_line = 1'b0;
    wait_ticks(T_EOD + 2);
    rx_line = 1'b1;
    clocks(2);
    chk("R9", int'(tx_grant), 0);
    wait_ticks(3);
    expect_ev(EV_EOD);
    expect_ev(EV_EOF);
    expect_ev(EV_GRANT);
    rx_line = 1'b0;
    wait_ticks(T_IFS + 3);

    // R10: break while sending aborts; break while idle is ignored
    tx_active = 1'b1;
    expect_ev(EV_ABORT);
    break_seen = 1'b1;
    clocks(1);
    break_seen = 1'b0;
    tx_active = 1'b0;
    clocks(3);
    break_seen = 1'b1;
    clocks(1);
    break_seen = 1'b0;
    clocks(3);
    chk("R10", int'(tx_abort), 0);

    clocks(20);
    chk("R3/R4/R6", exp_q.size(), 0);
    finish_run();
  end

endmodule